// File: doc/BRIEF.md
# Memory Load Execution Unit

This block takes one 16-bit load instruction of a small 32-bit RISC core at a time and carries it out. It decodes the instruction and reads the base registers through two combinational read ports in the cycle it accepts the instruction. From the addressing mode and the size-scaled displacement it forms the effective address. It then holds one read request on a valid/ready memory port until memory answers.

When the data returns, the block zero-extends short loads and produces the register write-backs. A stack pop can write two targets in one cycle: the loaded value goes to a general register, a dedicated register or the status word, and the stack pointer R15 receives its post-incremented value on a separate write port.

The pipeline sees `busy` while an instruction is in flight and a one-cycle `done` pulse when it completes. Encodings that are not loads complete at once with an `illegal` pulse and cause no memory traffic.

Top module: `ldExecUnit`

## Requirements
- R1: Word loads (size code 2 on `memSize`) use five addressing modes. Opcode `instr[15:8]`=0x04 reads at Rj. 0x00 reads at R13+Rj. 0x03 reads at R15 plus an unsigned offset. 0x07 reads at R15. Class `instr[15:12]`=0x2 reads at R14 plus an offset. Rj is `instr[7:4]` and the destination Ri is `instr[3:0]`.
- R2: For opcode 0x07 the field `instr[7:4]` selects the target. 0 writes general register Ri. 8 writes dedicated register number `instr[3:0]`. 9 writes the status word.
- R3: Halfword loads (size code 1) use opcode 0x05 (at Rj), opcode 0x01 (at R13+Rj) and class 0x4 (at R14 plus offset). Byte loads (size code 0) use opcode 0x06, opcode 0x01's byte counterpart 0x02, and class 0x6.
- R4: In classes 0x2, 0x4 and 0x6 the 8-bit field `instr[11:4]` is sign-extended. It is then shifted left by 2 for words, by 1 for halfwords and by 0 for bytes before it is added to R14 (modulo 2^32).
- R5: For opcode 0x03 the 4-bit field `instr[7:4]` is unsigned, and the address is R15 + 4 * field.
- R6: A pop (opcode 0x07) reads at the current R15 and drives `spWrEn` with `spWrData` = old R15 + 4, in the same cycle as the loaded-value write.
- R7: Halfword and byte loads deliver the low 16 or 8 bits of `memRdata` with zero upper bits. Word loads deliver all 32 bits.
- R8: `psWrEn` is raised only by the status-word pop, which delivers the full word on `psWrData`. That pop completes two cycles after the accepted ready. No other load touches the status word.
- R9: `memReq` rises in the cycle after acceptance and stays high with a stable address and size until `memReady`. `done` and the write enables pulse for exactly one cycle, in the cycle after the ready (except under R8). After that the unit is idle.
- R10: A pop into general register 15 writes the loaded value to R15 through `gprWrEn` and does not raise `spWrEn`.
- R11: Any other encoding, including 0x07 with a selector other than 0, 8 or 9, raises `illegal` and `done` together in the cycle after acceptance. It causes no memory request and no register write.
- R12: `instValid` is ignored while `busy` is high. The request in flight keeps its address, and no second request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction offered; accepted when idle |
| instr | input | 16 | Load instruction word |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Completion of an undecodable instruction |
| rdIdxA | output | 4 | Base register read index |
| rdDataA | input | 32 | Base register value |
| rdIdxB | output | 4 | Index register read index (Rj) |
| rdDataB | input | 32 | Index register value |
| memReq | output | 1 | Read request valid |
| memAddr | output | 32 | Read byte address |
| memSize | output | 2 | 0 byte, 1 halfword, 2 word |
| memReady | input | 1 | Memory accepts and returns data this cycle |
| memRdata | input | 32 | Returned data, right-aligned |
| gprWrEn | output | 1 | General register write |
| gprWrIdx | output | 4 | General register index |
| gprWrData | output | 32 | General register data |
| dedWrEn | output | 1 | Dedicated register write |
| dedWrIdx | output | 4 | Dedicated register number |
| dedWrData | output | 32 | Dedicated register data |
| psWrEn | output | 1 | Status word write |
| psWrData | output | 32 | Status word data (flags in bits 3:0) |
| spWrEn | output | 1 | Stack pointer post-increment write |
| spWrData | output | 32 | New stack pointer |

## Verification
Every upper opcode byte is swept, along with every 8-bit offset in each displacement class and every unsigned R15 offset and pop selector. A base of R14 close to zero forces negative offsets to wrap, so a decoder that zero-extends or scales by the wrong size produces a wrong address. A pop into R15 checks that the loaded value wins and the increment is dropped; a design that lets both writes through would clobber the pop. A status-word pop checks that its completion is one cycle later and that no other load raises the status write. Instructions offered during a request must leave the address untouched, and no second request may appear after the first one completes.

// File: rtl/ldExecPkg.sv
package ldExecPkg;
  localparam int XLEN    = 32;
  localparam int RIDX_W  = 4;
  localparam int OFS_W   = 8;
  localparam int UOFS_W  = 4;
  localparam int SP_STEP = 4;
  localparam int N_SIZES = 3;
  localparam logic [RIDX_W-1:0] IDX_R13 = 4'd13;
  localparam logic [RIDX_W-1:0] IDX_R14 = 4'd14;
  localparam logic [RIDX_W-1:0] IDX_R15 = 4'd15;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} sizeT;
  typedef enum logic [1:0] {DST_GPR = 2'd0, DST_DED = 2'd1, DST_PS = 2'd2} destT;

  typedef struct packed {
    logic              legal;
    sizeT              size;
    destT              dest;
    logic              isPop;
    logic              useRegB;
    logic [RIDX_W-1:0] baseIdx;
    logic [RIDX_W-1:0] ri;
    logic [XLEN-1:0]   disp;
  } decT;

  typedef struct packed {
    logic capture;
    logic latchData;
    logic writeBack;
  } ctlT;

  function automatic logic [XLEN-1:0] zeroExtend(input logic [XLEN-1:0] raw, input sizeT sz);
    case (sz)
      SZ_BYTE: return {{(XLEN-8){1'b0}}, raw[7:0]};
      SZ_HALF: return {{(XLEN-16){1'b0}}, raw[15:0]};
      default: return raw;
    endcase
  endfunction
endpackage

// File: rtl/ldDecoder.sv
module ldDecoder
  import ldExecPkg::*;
(
  input  logic [15:0] instr,
  output decT         dec
);
  logic [7:0]        opc;
  logic [3:0]        cls;
  logic [3:0]        fieldA;
  logic [3:0]        fieldB;
  logic [XLEN-1:0]   sextOfs;
  logic [XLEN-1:0]   scaledOfs [N_SIZES];

  assign opc     = instr[15:8];
  assign cls     = instr[15:12];
  assign fieldA  = instr[7:4];
  assign fieldB  = instr[3:0];
  assign sextOfs = {{(XLEN-OFS_W){instr[11]}}, instr[11:4]};

  // One pre-scaled copy of the signed offset per access size
  for (genvar g = 0; g < N_SIZES; g++) begin : gScale
    assign scaledOfs[g] = sextOfs << g;
  end

  always_comb begin
    dec         = '0;
    dec.size    = SZ_WORD;
    dec.dest    = DST_GPR;
    dec.ri      = fieldB;
    dec.baseIdx = fieldA;
    if (cls == 4'h2 || cls == 4'h4 || cls == 4'h6) begin
      dec.legal   = 1'b1;
      dec.baseIdx = IDX_R14;
      case (cls)
        4'h2: begin dec.size = SZ_WORD; dec.disp = scaledOfs[2]; end
        4'h4: begin dec.size = SZ_HALF; dec.disp = scaledOfs[1]; end
        default: begin dec.size = SZ_BYTE; dec.disp = scaledOfs[0]; end
      endcase
    end else begin
      case (opc)
        8'h04: begin dec.legal = 1'b1; dec.size = SZ_WORD; end
        8'h05: begin dec.legal = 1'b1; dec.size = SZ_HALF; end
        8'h06: begin dec.legal = 1'b1; dec.size = SZ_BYTE; end
        8'h00: begin
          dec.legal = 1'b1; dec.size = SZ_WORD; dec.useRegB = 1'b1; dec.baseIdx = IDX_R13;
        end
        8'h01: begin
          dec.legal = 1'b1; dec.size = SZ_HALF; dec.useRegB = 1'b1; dec.baseIdx = IDX_R13;
        end
        8'h02: begin
          dec.legal = 1'b1; dec.size = SZ_BYTE; dec.useRegB = 1'b1; dec.baseIdx = IDX_R13;
        end
        8'h03: begin
          dec.legal   = 1'b1;
          dec.baseIdx = IDX_R15;
          dec.disp    = {{(XLEN-UOFS_W-2){1'b0}}, fieldA, 2'b00};
        end
        8'h07: begin
          dec.baseIdx = IDX_R15;
          dec.isPop   = 1'b1;
          case (fieldA)
            4'h0: begin dec.legal = 1'b1; dec.dest = DST_GPR; end
            4'h8: begin dec.legal = 1'b1; dec.dest = DST_DED; end
            4'h9: begin dec.legal = 1'b1; dec.dest = DST_PS;  end
            default: dec.legal = 1'b0;
          endcase
        end
        default: dec.legal = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ldControl.sv
module ldControl
  import ldExecPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic instValid,
  input  logic decLegal,
  input  logic destIsPs,
  input  logic memReady,
  output ctlT  ctl,
  output logic memReq,
  output logic busy,
  output logic done,
  output logic illegal
);
  typedef enum logic [2:0] {S_IDLE, S_REQ, S_FLAG, S_WB, S_ILL} stateT;
  stateT state, stateNext;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    memReq    = 1'b0;
    case (state)
      S_IDLE: if (instValid) begin
        ctl.capture = 1'b1;
        stateNext   = decLegal ? S_REQ : S_ILL;
      end
      S_REQ: begin
        memReq = 1'b1;
        if (memReady) begin
          ctl.latchData = 1'b1;
          stateNext     = destIsPs ? S_FLAG : S_WB;
        end
      end
      S_FLAG: stateNext = S_WB;
      S_WB: begin
        ctl.writeBack = 1'b1;
        stateNext     = S_IDLE;
      end
      S_ILL:   stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign busy    = (state != S_IDLE);
  assign done    = (state == S_WB) || (state == S_ILL);
  assign illegal = (state == S_ILL);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq);
  p_done_after_ready_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memReady && !destIsPs |=> done);
  p_ps_extra_cycle_r8: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memReady && destIsPs |=> !done);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_ill_noreq_r11: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> done && !memReq);
endmodule

// File: rtl/ldDatapath.sv
module ldDatapath
  import ldExecPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlT               ctl,
  input  decT               dec,
  input  logic [XLEN-1:0]   rdDataA,
  input  logic [XLEN-1:0]   rdDataB,
  input  logic [XLEN-1:0]   memRdata,
  output logic [XLEN-1:0]   memAddr,
  output logic [1:0]        memSize,
  output logic              destIsPs,
  output logic              gprWrEn,
  output logic [RIDX_W-1:0] gprWrIdx,
  output logic [XLEN-1:0]   gprWrData,
  output logic              dedWrEn,
  output logic [RIDX_W-1:0] dedWrIdx,
  output logic [XLEN-1:0]   dedWrData,
  output logic              psWrEn,
  output logic [XLEN-1:0]   psWrData,
  output logic              spWrEn,
  output logic [XLEN-1:0]   spWrData
);
  logic [XLEN-1:0]   addrQ, spNextQ, dataQ, offset;
  sizeT              sizeQ;
  destT              destQ;
  logic              popQ;
  logic [RIDX_W-1:0] riQ;

  assign offset = dec.useRegB ? rdDataB : dec.disp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      spNextQ <= '0;
      dataQ   <= '0;
      sizeQ   <= SZ_BYTE;
      destQ   <= DST_GPR;
      popQ    <= 1'b0;
      riQ     <= '0;
    end else begin
      if (ctl.capture) begin
        addrQ   <= rdDataA + offset;
        spNextQ <= rdDataA + XLEN'(SP_STEP);
        sizeQ   <= dec.size;
        destQ   <= dec.dest;
        popQ    <= dec.isPop;
        riQ     <= dec.ri;
      end
      if (ctl.latchData) dataQ <= zeroExtend(memRdata, sizeQ);
    end
  end

  assign memAddr   = addrQ;
  assign memSize   = sizeQ;
  assign destIsPs  = (destQ == DST_PS);
  assign gprWrEn   = ctl.writeBack && (destQ == DST_GPR);
  assign gprWrIdx  = riQ;
  assign gprWrData = dataQ;
  assign dedWrEn   = ctl.writeBack && (destQ == DST_DED);
  assign dedWrIdx  = riQ;
  assign dedWrData = dataQ;
  assign psWrEn    = ctl.writeBack && (destQ == DST_PS);
  assign psWrData  = dataQ;
  // Loaded value to R15 takes precedence over the post-increment
  assign spWrEn    = ctl.writeBack && popQ && !((destQ == DST_GPR) && (riQ == IDX_R15));
  assign spWrData  = spNextQ;

  p_r15_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    spWrEn |-> !(gprWrEn && gprWrIdx == IDX_R15));
  p_ps_pops_sp_r8: assert property (@(posedge clk) disable iff (!rstN)
    psWrEn |-> spWrEn);
endmodule

// File: rtl/ldExecUnit.sv
module ldExecUnit
  import ldExecPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instValid,
  input  logic [15:0] instr,
  output logic        busy,
  output logic        done,
  output logic        illegal,
  output logic [3:0]  rdIdxA,
  input  logic [31:0] rdDataA,
  output logic [3:0]  rdIdxB,
  input  logic [31:0] rdDataB,
  output logic        memReq,
  output logic [31:0] memAddr,
  output logic [1:0]  memSize,
  input  logic        memReady,
  input  logic [31:0] memRdata,
  output logic        gprWrEn,
  output logic [3:0]  gprWrIdx,
  output logic [31:0] gprWrData,
  output logic        dedWrEn,
  output logic [3:0]  dedWrIdx,
  output logic [31:0] dedWrData,
  output logic        psWrEn,
  output logic [31:0] psWrData,
  output logic        spWrEn,
  output logic [31:0] spWrData
);
  decT  dec;
  ctlT  ctl;
  logic destIsPs;

  ldDecoder uDec (.instr(instr), .dec(dec));

  assign rdIdxA = dec.baseIdx;
  assign rdIdxB = instr[7:4];

  ldControl uCtl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .decLegal(dec.legal),
    .destIsPs(destIsPs), .memReady(memReady), .ctl(ctl), .memReq(memReq),
    .busy(busy), .done(done), .illegal(illegal)
  );

  ldDatapath uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dec(dec), .rdDataA(rdDataA),
    .rdDataB(rdDataB), .memRdata(memRdata), .memAddr(memAddr), .memSize(memSize),
    .destIsPs(destIsPs), .gprWrEn(gprWrEn), .gprWrIdx(gprWrIdx),
    .gprWrData(gprWrData), .dedWrEn(dedWrEn), .dedWrIdx(dedWrIdx),
    .dedWrData(dedWrData), .psWrEn(psWrEn), .psWrData(psWrData),
    .spWrEn(spWrEn), .spWrData(spWrData)
  );

  p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> $stable(memAddr) && $stable(memSize));
  p_wr_only_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    (gprWrEn || dedWrEn || psWrEn || spWrEn) |-> done && !illegal);
endmodule

// File: tb/sim_ldExecUnit.sv
module sim_ldExecUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [15:0] instr = '0;
  logic        busy, done, illegal;
  logic [3:0]  rdIdxA, rdIdxB;
  logic [31:0] rdDataA, rdDataB;
  logic        memReq;
  logic [31:0] memAddr;
  logic [1:0]  memSize;
  logic        memReady = 1'b0;
  logic [31:0] memRdata = '0;
  logic        gprWrEn, dedWrEn, psWrEn, spWrEn;
  logic [3:0]  gprWrIdx, dedWrIdx;
  logic [31:0] gprWrData, dedWrData, psWrData, spWrData;

  logic [31:0] regs [16];
  int nVec = 0;
  int nBad = 0;
  int patSeed = 0;

  always #10 clk = ~clk;

  always_comb rdDataA = regs[rdIdxA];
  always_comb rdDataB = regs[rdIdxB];

  ldExecUnit u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h instr=%h", req, act, exp, instr);
    end
  endtask

  task automatic loadRegs(input logic [31:0] seed, input logic [31:0] r14);
    for (int i = 0; i < 16; i++)
      regs[i] = (32'h0100_0000 * (i + 1)) ^ (seed * 32'h9E37_79B9) ^ (i * 32'h0001_0104);
    regs[14] = r14;
  endtask

  // kind: 0 general register, 1 dedicated, 2 status word
  task automatic expectOf(input logic [15:0] ins, output bit legal, output logic [31:0] addr,
                          output logic [1:0] sz, output int kind, output bit pop, output string tag);
    logic [3:0] rj;
    logic [31:0] ofs;
    rj = ins[7:4];
    legal = 1'b1; pop = 1'b0; kind = 0; addr = '0; sz = 2'd2; tag = "R1";
    ofs = {{24{ins[11]}}, ins[11:4]};
    if (ins[15:12] == 4'h2) begin addr = regs[14] + ofs * 4; sz = 2'd2; tag = "R4"; end
    else if (ins[15:12] == 4'h4) begin addr = regs[14] + ofs * 2; sz = 2'd1; tag = "R4"; end
    else if (ins[15:12] == 4'h6) begin addr = regs[14] + ofs; sz = 2'd0; tag = "R4"; end
    else begin
      case (ins[15:8])
        8'h04: begin addr = regs[rj]; sz = 2'd2; tag = "R1"; end
        8'h00: begin addr = regs[13] + regs[rj]; sz = 2'd2; tag = "R1"; end
        8'h05: begin addr = regs[rj]; sz = 2'd1; tag = "R3"; end
        8'h01: begin addr = regs[13] + regs[rj]; sz = 2'd1; tag = "R3"; end
        8'h06: begin addr = regs[rj]; sz = 2'd0; tag = "R3"; end
        8'h02: begin addr = regs[13] + regs[rj]; sz = 2'd0; tag = "R3"; end
        8'h03: begin addr = regs[15] + 32'(rj) * 4; sz = 2'd2; tag = "R5"; end
        8'h07: begin
          addr = regs[15]; sz = 2'd2; pop = 1'b1; tag = "R6";
          if (rj == 4'd0) kind = 0;
          else if (rj == 4'd8) kind = 1;
          else if (rj == 4'd9) kind = 2;
          else legal = 1'b0;
        end
        default: legal = 1'b0;
      endcase
    end
  endtask

  task automatic doVector(input logic [15:0] ins, input int delay, input bit disturb);
    bit legal, pop, spExp;
    int kind;
    string tag;
    logic [31:0] expAddr, pat, expVal;
    logic [1:0] expSz;
    expectOf(ins, legal, expAddr, expSz, kind, pop, tag);
    @(negedge clk);
    instr = ins; instValid = 1'b1;
    @(negedge clk);
    instValid = 1'b0;
    if (!legal) begin
      chk(illegal && done && !memReq && !gprWrEn && !dedWrEn && !psWrEn && !spWrEn,
          "R11", {illegal, done, memReq, gprWrEn, dedWrEn, psWrEn, spWrEn}, 32'h60);
      @(negedge clk);
      chk(!busy && !done && !memReq, "R11", {busy, done, memReq}, 32'h0);
      return;
    end
    chk(memReq && !illegal, "R9", {memReq, illegal}, 32'h2);
    chk(memAddr == expAddr, tag, memAddr, expAddr);
    chk(memSize == expSz, (expSz == 2'd2) ? "R1" : "R3", 32'(memSize), 32'(expSz));
    for (int k = 0; k < delay; k++) begin
      if (disturb && k == 0) begin instr = 16'h04F3; instValid = 1'b1; end
      @(negedge clk);
      instValid = 1'b0;
      chk(memReq && memAddr == expAddr && !done, disturb ? "R12" : "R9", memAddr, expAddr);
    end
    patSeed++;
    pat = {expAddr[15:0] ^ 16'hBEEF, expAddr[31:16] ^ 16'h1357} + (patSeed * 32'h0101_0011);
    memRdata = pat; memReady = 1'b1;
    @(negedge clk);
    memReady = 1'b0; memRdata = '0;
    if (kind == 2) begin
      chk(!done && !psWrEn, "R8", {done, psWrEn}, 32'h0);
      @(negedge clk);
    end
    chk(done && !illegal, "R9", {done, illegal}, 32'h2);
    expVal = (expSz == 2'd0) ? {24'h0, pat[7:0]} : (expSz == 2'd1) ? {16'h0, pat[15:0]} : pat;
    chk(gprWrEn == (kind == 0), "R2", 32'(gprWrEn), 32'(kind == 0));
    chk(dedWrEn == (kind == 1), "R2", 32'(dedWrEn), 32'(kind == 1));
    chk(psWrEn == (kind == 2), "R8", 32'(psWrEn), 32'(kind == 2));
    if (kind == 0) begin
      chk(gprWrData == expVal, (pop && ins[3:0] == 4'd15) ? "R10" : "R7", gprWrData, expVal);
      chk(gprWrIdx == ins[3:0], "R1", 32'(gprWrIdx), 32'(ins[3:0]));
    end else if (kind == 1) begin
      chk(dedWrData == pat && dedWrIdx == ins[3:0], "R2", dedWrData, pat);
    end else begin
      chk(psWrData == pat, "R8", psWrData, pat);
    end
    spExp = pop && !(kind == 0 && ins[3:0] == 4'd15);
    chk(spWrEn == spExp, pop ? "R10" : "R6", 32'(spWrEn), 32'(spExp));
    if (spExp) chk(spWrData == regs[15] + 32'd4, "R6", spWrData, regs[15] + 32'd4);
    @(negedge clk);
    chk(!done && !busy && !memReq && !gprWrEn && !spWrEn, disturb ? "R12" : "R9",
        {done, busy, memReq, gprWrEn, spWrEn}, 32'h0);
  endtask

  task automatic finishRun;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    nVec++; nBad++;
    $display("FAIL R9 watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    finishRun();
  end

  initial begin
    loadRegs(32'h1, 32'h2000_0400);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !illegal && !memReq, "R9", {busy, done, illegal, memReq}, 32'h0);
    chk(!gprWrEn && !dedWrEn && !psWrEn && !spWrEn, "R8",
        {gprWrEn, dedWrEn, psWrEn, spWrEn}, 32'h0);

    // Every upper opcode byte with two low bytes
    for (int hi = 0; hi < 256; hi++) begin
      doVector({hi[7:0], 8'h3A}, hi % 3, 1'b0);
      doVector({hi[7:0], 8'hF5}, (hi + 1) % 3, 1'b0);
    end

    // All signed offsets in each displacement class, two R14 bases
    for (int pass = 0; pass < 2; pass++) begin
      loadRegs(32'(pass + 7), pass == 0 ? 32'h0000_0010 : 32'hFFFF_FFF8);
      for (int c = 0; c < 3; c++)
        for (int o = 0; o < 256; o++)
          doVector({4'(2 + 2 * c), o[7:0], o[3:0]}, o % 2, 1'b0);
    end

    // Unsigned R15 offsets and every pop selector
    loadRegs(32'h33, 32'h4000_0000);
    for (int u = 0; u < 16; u++)
      for (int r = 0; r < 16; r++) begin
        doVector({8'h03, u[3:0], r[3:0]}, 0, 1'b0);
        doVector({8'h07, u[3:0], r[3:0]}, r % 2, 1'b0);
      end

    // Offers while busy
    loadRegs(32'h55, 32'h1234_5670);
    doVector(16'h0512, 2, 1'b1);
    doVector(16'h0798, 3, 1'b1);
    doVector(16'h07F0, 2, 1'b1);
    doVector(16'h4FF1, 2, 1'b1);

    finishRun();
  end
endmodule